// File: doc/BRIEF.md
# I2C Start/Stop Condition Generator with Delayed SDA

This block drives the two lines of an I2C bus as a master, but only to form bus conditions: start, stop and repeated start. A down-counter reloaded from `baud_n` marks every half period of SCL. The counter counts only in cycles where `cs_en` is high, so one SCL half period lasts `baud_n`+1 enabled cycles, and the full SCL period is twice that. Every step of a condition is applied on one of these half-period marks. Steps that move SCL take effect at the mark itself. Steps that move SDA pass through a delay line of `dly_code` enabled cycles before they reach the pin.

Because SDA lags SCL by the delay, the hold time after a start shrinks by the delay. The setup time before a stop grows by the same amount. For example, a reload value of 99 with a 20 MHz count source gives a 5 µs half period. A 6-cycle delay then leaves a 4.7 µs start hold and a 5.3 µs stop setup.

Both outputs are drive-low enables for open-drain pads: 1 pulls the line low and 0 releases it. The driver holds `baud_n` and `dly_code` steady while `busy` is high. It keeps `baud_n` at 7 or more, so that the longest delay fits inside a half period. A start is issued from a released bus. Repeated start and stop are issued after a start, while SCL is held low.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset, `scl_low` and `sda_low` are 0 (both lines released), and `busy` and `done` are 0. The same holds after a reset applied in the middle of a condition.
- R2: SCL changes only on a half-period mark. Marks are `baud_n`+1 enabled cycles apart, and cycles with `cs_en` low do not advance them. In a repeated start, SCL stays released for exactly 2×(`baud_n`+1) enabled cycles.
- R3: A start drives SDA low while SCL is released, then drives SCL low. The gap from the SDA fall to the SCL fall is (`baud_n`+1) − `dly_code` enabled cycles.
- R4: A stop keeps SDA low, releases SCL, and then releases SDA while SCL is released. The gap from the SCL rise to the SDA rise is (`baud_n`+1) + `dly_code` enabled cycles.
- R5: A repeated start releases SDA while SCL is low, releases SCL, drives SDA low, and finally drives SCL low. The gap from the SCL rise to the SDA fall is (`baud_n`+1) + `dly_code` enabled cycles. The gap from the SDA fall to the SCL fall is (`baud_n`+1) − `dly_code` enabled cycles.
- R6: With `dly_code` 0, an SDA change appears on the half-period mark itself. With a nonzero code k, the change appears k enabled cycles after the mark.
- R7: A request is taken only while `busy` is 0, and `busy` is 1 from the next clock edge. A request made while `busy` is 1 has no effect on the condition in progress.
- R8: `done` is high for one clock cycle, on the first enabled cycle after the final bus edge of the condition. `busy` returns to 0 on the same edge. The final bus edge is the SCL fall for a start or repeated start, and the SDA release for a stop.
- R9: When several request strobes are high in the same cycle, start wins over repeated start, and repeated start wins over stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_en | input | 1 | Count-source enable; counters and the delay line advance only when high |
| baud_n | input | 8 | Half-period reload value; a half period is baud_n+1 enabled cycles |
| dly_code | input | 3 | SDA delay in enabled cycles, 0 for none |
| req_start | input | 1 | Request a start condition |
| req_stop | input | 1 | Request a stop condition |
| req_restart | input | 1 | Request a repeated start condition |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it (delayed) |
| busy | output | 1 | A condition is in progress |
| done | output | 1 | One-cycle pulse when a condition completes |

## Verification
Each reload and delay pair is run through a full start, repeated start and stop sequence. The pairs are a short period with no delay, a mid delay, the largest delay, and a count source enabled only every other cycle. The zero-delay case shows whether SDA moves exactly on the mark. The largest code shows whether the hold and setup gaps move in opposite directions by the full delay. The gated case tells counting in enabled cycles apart from counting in clock cycles. Directed cases issue a stop during a start and issue competing strobes in one cycle. The final bus levels then reveal which request took effect. A last case resets the block in the middle of a condition.

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen #(
  parameter int BAUD_W = 8,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_en,
  input  logic [BAUD_W-1:0] baud_n,
  input  logic [DLY_W-1:0]  dly_code,
  input  logic              req_start,
  input  logic              req_stop,
  input  logic              req_restart,
  output logic              scl_low,
  output logic              sda_low,
  output logic              busy,
  output logic              done
);

  localparam int DLY_MAX = (1 << DLY_W) - 1;

  typedef enum logic [3:0] {
    S_IDLE, S_ST_SDA, S_ST_SCL,
    S_SP_SDA0, S_SP_SCL, S_SP_SDA1,
    S_RS_SDA1, S_RS_SCL1, S_RS_SDA0, S_RS_SCL0,
    S_DRAIN
  } state_t;

  typedef enum logic [1:0] {OP_NONE, OP_START, OP_STOP, OP_RESTART} op_t;

  state_t state;
  op_t    op_q;
  logic [BAUD_W-1:0] bcnt;
  logic [DLY_W-1:0]  dcnt;
  logic [DLY_MAX-1:0] pipe;
  logic sda_int;
  logic tick;

  assign tick = cs_en && (bcnt == '0);
  assign sda_low = (dly_code == '0) ? sda_int : pipe[dly_code - 1'b1];

  always_ff @(posedge clk) begin
    if (!rst_n)
      bcnt <= baud_n;
    else if (tick)
      bcnt <= baud_n;
    else if (cs_en)
      bcnt <= bcnt - 1'b1;
  end

  generate
    if (DLY_MAX > 1) begin : g_pipe
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else if (cs_en) pipe <= {pipe[DLY_MAX-2:0], sda_int};
      end
    end else begin : g_pipe1
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else if (cs_en) pipe <= sda_int;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_NONE;
      scl_low <= 1'b0;
      sda_int <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      dcnt    <= '0;
    end else begin
      done <= 1'b0;
      if (cs_en && dcnt != '0) dcnt <= dcnt - 1'b1;
      case (state)
        S_IDLE: begin
          if (req_start) begin
            state <= S_ST_SDA;  op_q <= OP_START;   busy <= 1'b1;
          end else if (req_restart) begin
            state <= S_RS_SDA1; op_q <= OP_RESTART; busy <= 1'b1;
          end else if (req_stop) begin
            state <= S_SP_SDA0; op_q <= OP_STOP;    busy <= 1'b1;
          end
        end
        S_ST_SDA:  if (tick) begin sda_int <= 1'b1; dcnt <= dly_code; state <= S_ST_SCL; end
        S_ST_SCL:  if (tick) begin scl_low <= 1'b1; state <= S_DRAIN; end
        S_SP_SDA0: if (tick) begin sda_int <= 1'b1; dcnt <= dly_code; state <= S_SP_SCL; end
        S_SP_SCL:  if (tick) begin scl_low <= 1'b0; state <= S_SP_SDA1; end
        S_SP_SDA1: if (tick) begin sda_int <= 1'b0; dcnt <= dly_code; state <= S_DRAIN; end
        S_RS_SDA1: if (tick) begin sda_int <= 1'b0; dcnt <= dly_code; state <= S_RS_SCL1; end
        S_RS_SCL1: if (tick) begin scl_low <= 1'b0; state <= S_RS_SDA0; end
        S_RS_SDA0: if (tick) begin sda_int <= 1'b1; dcnt <= dly_code; state <= S_RS_SCL0; end
        S_RS_SCL0: if (tick) begin scl_low <= 1'b1; state <= S_DRAIN; end
        S_DRAIN: begin
          if (cs_en && dcnt == '0) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_frees_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(req_start || req_stop || req_restart)) |=> !busy);

  a_r2_scl_on_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_low != $past(scl_low)) |-> $past(tick));

  a_r3_start_sda_under_high_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_START && $rose(sda_low)) |-> !scl_low);

  a_r4_stop_sda_under_high_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_STOP && $fell(sda_low)) |-> !scl_low);

endmodule

// File: tb/sim_i2c_cond_gen.sv
module sim_i2c_cond_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  // columns: baud_n, dly_code, gated count source
  localparam int VEC [0:NV-1][0:2] = '{
    '{7, 0, 0},
    '{9, 3, 0},
    '{15, 7, 0},
    '{12, 5, 1}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic cs_en = 1;
  logic [7:0] baud_n = 8'd7;
  logic [2:0] dly_code = 3'd0;
  logic req_start = 0, req_stop = 0, req_restart = 0;
  logic scl_low, sda_low, busy, done;

  i2c_cond_gen u0 (.clk, .rst_n, .cs_en, .baud_n, .dly_code, .req_start, .req_stop,
                   .req_restart, .scl_low, .sda_low, .busy, .done);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  int cyc = 0;
  int gated = 0;
  int t_sda_fall, t_sda_rise, t_scl_fall, t_scl_rise, t_done;
  int ndone = 0;
  logic p_scl = 0, p_sda = 0, p_done = 0;
  bit  wide_done = 0;

  always @(posedge clk) if (cs_en) cyc = cyc + 1;

  always @(negedge clk) begin
    if (sda_low && !p_sda) t_sda_fall = cyc;
    if (!sda_low && p_sda) t_sda_rise = cyc;
    if (scl_low && !p_scl) t_scl_fall = cyc;
    if (!scl_low && p_scl) t_scl_rise = cyc;
    if (done) begin t_done = cyc; ndone++; if (p_done) wide_done = 1; end
    p_sda = sda_low; p_scl = scl_low; p_done = done;
  end

  always @(negedge clk) begin
    if (gated != 0) cs_en <= ~cs_en;
    else cs_en <= 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_op(input int which, input bit extra_stop);
    int n0;
    @(negedge clk);
    req_start = (which == 0); req_restart = (which == 1); req_stop = (which == 2);
    @(negedge clk);
    req_start = 0; req_restart = 0; req_stop = 0;
    chk("R7 busy rises after request", int'(busy), 1);
    if (extra_stop) begin
      @(negedge clk); req_stop = 1;
      @(negedge clk); req_stop = 0;
    end
    n0 = ndone;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (ndone != n0) break;
    end
    chk("R8 condition completes", int'(ndone != n0), 1);
    @(negedge clk);
    chk("R8 busy low after done", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 scl released at reset", int'(scl_low), 0);
    chk("R1 sda released at reset", int'(sda_low), 0);
    chk("R1 busy low at reset", int'(busy), 0);
    chk("R1 done low at reset", int'(done), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int n, k, hp;
      n = VEC[v][0]; k = VEC[v][1]; gated = VEC[v][2];
      hp = n + 1;
      baud_n = 8'(n); dly_code = 3'(k);
      repeat (2) @(negedge clk);
      run_op(0, 0);
      chk("R3 R6 start hold", t_scl_fall - t_sda_fall, hp - k);
      chk("R8 start done timing", t_done - t_scl_fall, 1);
      chk("R3 start end levels", int'({scl_low, sda_low}), 3);
      run_op(1, 0);
      chk("R5 restart setup", t_sda_fall - t_scl_rise, hp + k);
      chk("R5 R6 restart hold", t_scl_fall - t_sda_fall, hp - k);
      chk("R2 restart scl high width", t_scl_fall - t_scl_rise, 2 * hp);
      chk("R8 restart done timing", t_done - t_scl_fall, 1);
      run_op(2, 0);
      chk("R4 R6 stop setup", t_sda_rise - t_scl_rise, hp + k);
      chk("R8 stop done timing", t_done - t_sda_rise, 1);
      chk("R4 stop end levels", int'({scl_low, sda_low}), 0);
    end
    gated = 0;
    baud_n = 8'd8; dly_code = 3'd2;
    repeat (2) @(negedge clk);

    begin
      int n0;
      n0 = ndone;
      run_op(0, 1);
      chk("R7 stop during start ignored", int'({scl_low, sda_low}), 3);
      chk("R7 single done", ndone - n0, 1);
      repeat (40) @(negedge clk);
      chk("R7 stays idle", int'(busy), 0);
      run_op(2, 0);
    end

    @(negedge clk);
    req_start = 1; req_stop = 1;
    @(negedge clk);
    req_start = 0; req_stop = 0;
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    chk("R9 start beats stop", int'({scl_low, sda_low}), 3);

    @(negedge clk);
    req_restart = 1; req_stop = 1;
    @(negedge clk);
    req_restart = 0; req_stop = 0;
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    chk("R9 restart beats stop", int'({scl_low, sda_low}), 3);

    @(negedge clk);
    req_stop = 1;
    @(negedge clk);
    req_stop = 0;
    repeat (12) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 mid-condition reset levels", int'({scl_low, sda_low}), 0);
    chk("R1 mid-condition reset busy", int'({busy, done}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    chk("R8 done one cycle wide", int'(wide_done), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule